// File: doc/BRIEF.md
# Glitch-free gated clock divider

The block derives three slower clocks from one input clock: one at half, one at a quarter and one at an eighth of the input frequency. All three come from a single synchronous eight-phase down counter, so every edge they have in common happens on the same input rising edge. The outputs are register bits, so they never glitch.

A run input starts and stops all three outputs together. It is sampled on the falling edge of the input clock, and a rising edge advances the counter only if run was high at the falling edge just before it. A run change therefore reaches the divider only while the input clock is low, and no output pulse can be shortened. A clear input forces the divider into a known phase. Several instances that are cleared together stay in step.

The enable path is a two-state machine, clocked on the falling edge:
- GATE_OFF goes to GATE_ON when run is high.
- GATE_ON goes to GATE_OFF when run is low.

The divider is an eight-state machine PH0..PH7, where each state's code is its count. On an enabled rising edge it steps PH0→PH7, PH7→PH6, PH6→PH5 and so on, down to PH1→PH0. Without the gate it stays in its state.

Top module: `gated_clock_divider`

## Requirements
- R1: While clr_i is high, div2_o, div4_o and div8_o are all low, whatever run_i does. Clear acts at once, without waiting for a clock edge.
- R2: With run_i held high, div2_o changes on every rising edge of clk_i, giving a period of exactly 2 input periods.
- R3: With run_i held high, div4_o has a period of exactly 4 input periods and div8_o a period of exactly 8.
- R4: The phase count is a 3-bit value. Each enabled rising edge lowers it by one, and 0 wraps to 7. div2_o is bit 0, div4_o is bit 1 and div8_o is bit 2. The first enabled edge after a clear raises all three outputs in the same cycle (phase 0 to 7). Whenever div8_o rises, div4_o and div2_o rise with it.
- R5: A rising edge of clk_i advances the count if and only if run_i was high at the falling edge just before it. A change of run_i after that falling edge has no effect until the next falling edge.
- R6: While the gate is off, all outputs hold their levels and the count is frozen. When run resumes, counting continues from the held count.
- R7: Outputs change only at rising edges of clk_i, apart from the asynchronous clear. Every high or low level therefore lasts a whole number of input periods.
- R8: After clr_i is released, the gate starts off. No count happens until a falling edge has seen run_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to divide |
| run_i | input | 1 | Common enable, sampled on the falling edge of clk_i |
| clr_i | input | 1 | Asynchronous active-high clear of gate and divider |
| div2_o | output | 1 | Input clock divided by 2 |
| div4_o | output | 1 | Input clock divided by 4 |
| div8_o | output | 1 | Input clock divided by 8 |

## Verification
A long steady-run stretch measures the rise-to-rise spacing of each output. This tells correct division ratios apart from a counter that skips or repeats a phase. Directed steps drive run one way during the high half of the clock and the other way during the low half. This separates capture on the falling edge from capture on the rising edge, or from a gate that follows run directly. Random run patterns from a fixed seed, plus clears in the middle of a run, are compared cycle by cycle against a bench count model. A monitor of edge times flags any output change away from a rising clock edge, which would show up as a shortened pulse.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int unsigned DIV_BITS = 3;
    localparam int unsigned PHASES   = 1 << DIV_BITS;

    typedef enum logic [DIV_BITS-1:0] {
        PH0 = 3'd0,
        PH1 = 3'd1,
        PH2 = 3'd2,
        PH3 = 3'd3,
        PH4 = 3'd4,
        PH5 = 3'd5,
        PH6 = 3'd6,
        PH7 = 3'd7
    } phase_e;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_e;
endpackage

// File: rtl/clkdiv_gate_fsm.sv
module clkdiv_gate_fsm
    import clkdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic gate_on_o
);
    gate_e state_q, state_d;

    // State register on the falling edge: the gate only moves while the clock is low.
    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) state_q <= GATE_OFF;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: if (run_i)  state_d = GATE_ON;
            GATE_ON:  if (!run_i) state_d = GATE_OFF;
            default:  state_d = GATE_OFF;
        endcase
    end

    always_comb gate_on_o = (state_q == GATE_ON);
endmodule

// File: rtl/clkdiv_phase_fsm.sv
module clkdiv_phase_fsm
    import clkdiv_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                adv_i,
    output logic [DIV_BITS-1:0] phase_o
);
    phase_e state_q, state_d;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) state_q <= PH0;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (adv_i) begin
            unique case (state_q)
                PH0: state_d = PH7;
                PH7: state_d = PH6;
                PH6: state_d = PH5;
                PH5: state_d = PH4;
                PH4: state_d = PH3;
                PH3: state_d = PH2;
                PH2: state_d = PH1;
                PH1: state_d = PH0;
                default: state_d = PH0;
            endcase
        end
    end

    // The state code is the phase count, so each output bit is a register bit.
    always_comb phase_o = state_q;

    // R6: no advance request means the phase stays put
    a_r6_phase_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        !adv_i |=> $stable(state_q));

    // R4: an advance request steps the phase down by one
    a_r4_phase_steps: assert property (@(posedge clk_i) disable iff (rst_i)
        adv_i |=> (state_q == phase_e'($past(state_q) - 3'd1)));
endmodule

// File: rtl/gated_clock_divider.sv
module gated_clock_divider
    import clkdiv_pkg::*;
(
    input  logic clk_i,
    input  logic run_i,
    input  logic clr_i,
    output logic div2_o,
    output logic div4_o,
    output logic div8_o
);
    logic                gate_on;
    logic [DIV_BITS-1:0] phase;
    logic [DIV_BITS-1:0] div_w;

    clkdiv_gate_fsm u_gate (
        .clk_i     (clk_i),
        .rst_i     (clr_i),
        .run_i     (run_i),
        .gate_on_o (gate_on)
    );

    clkdiv_phase_fsm u_phase (
        .clk_i   (clk_i),
        .rst_i   (clr_i),
        .adv_i   (gate_on),
        .phase_o (phase)
    );

    for (genvar g = 0; g < DIV_BITS; g++) begin : g_tap
        assign div_w[g] = phase[g];
    end

    always_comb begin
        div2_o = div_w[0];
        div4_o = div_w[1];
        div8_o = div_w[2];
    end

    // R1: clear holds every output low
    a_r1_clear_low: assert property (@(posedge clk_i)
        clr_i |-> (div_w == '0));

    // R2: an open gate toggles the divide-by-2 output on the next edge
    a_r2_div2_toggles: assert property (@(posedge clk_i) disable iff (clr_i)
        gate_on |=> (div2_o != $past(div2_o)));

    // R6: a closed gate keeps every output level
    a_r6_outputs_hold: assert property (@(posedge clk_i) disable iff (clr_i)
        !gate_on |=> $stable(div_w));

    // R4: a rise of divide-by-8 is shared by the faster outputs
    a_r4_common_rise: assert property (@(posedge clk_i) disable iff (clr_i)
        $rose(div8_o) |-> ($rose(div4_o) && $rose(div2_o)));

    // R3: a rise of divide-by-4 is shared by divide-by-2
    a_r3_div4_with_div2: assert property (@(posedge clk_i) disable iff (clr_i)
        $rose(div4_o) |-> $rose(div2_o));
endmodule

// File: tb/gated_clock_divider_tb.sv
module gated_clock_divider_tb_top;
    logic clk = 1'b0;
    logic run = 1'b0;
    logic clr = 1'b1;
    logic d2, d4, d8;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;
    int unsigned m_cnt = 0;
    bit          m_gate = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gated_clock_divider dut_i (
        .clk_i (clk),
        .run_i (run),
        .clr_i (clr),
        .div2_o(d2),
        .div4_o(d4),
        .div8_o(d8)
    );

    function automatic int unsigned next_phase(int unsigned c);
        return (c + 7) % 8;
    endfunction

    function automatic logic [2:0] exp_outs(int unsigned c);
        return c[2:0];
    endfunction

    task automatic check3(string req, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs {div8,div4,div2} got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Entered at rising edge + 2 ns. hi is driven during the high phase and is
    // seen by the falling edge; lo is driven during the low phase.
    task automatic step(bit hi, bit lo, string req);
        run = hi;
        @(negedge clk);
        m_gate = hi;
        #2 run = lo;
        @(posedge clk);
        if (m_gate) m_cnt = next_phase(m_cnt);
        #2;
        check3(req, {d8, d4, d2}, exp_outs(m_cnt));
    endtask

    // R7: outputs may change only at rising edges (t = 4 mod 8) outside clear
    always @(d2 or d4 or d8) begin
        if (!clr && !done && $time > 0) begin
            n_chk++;
            if (($time % 8) != 4) begin
                n_bad++;
                $display("FAIL R7: output edge at time mod 8 = %0d expected 4", $time % 8);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] prev;
        logic [2:0] cur;
        int         last [3];
        bit         r;

        void'($urandom(32'd7319));

        // R1: outputs low under clear, with run high
        run = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check3("R1", {d8, d4, d2}, 3'b000);
        @(posedge clk); #2;
        check3("R1", {d8, d4, d2}, 3'b000);

        // Release clear; gate starts off
        clr = 1'b0;
        m_cnt = 0;
        m_gate = 1'b0;
        step(1'b0, 1'b1, "R8");
        step(1'b1, 1'b1, "R4");   // 0 -> 7: all outputs rise together
        check3("R4", {d8, d4, d2}, 3'b111);

        // R2/R3: period measurement with run held high
        prev = {d8, d4, d2};
        for (int b = 0; b < 3; b++) last[b] = -1;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b1, "R2");
            cur = {d8, d4, d2};
            for (int b = 0; b < 3; b++) begin
                if (cur[b] && !prev[b]) begin
                    if (last[b] >= 0) check_int((b == 0) ? "R2" : "R3", i - last[b], 2 << b);
                    last[b] = i;
                end
            end
            prev = cur;
        end

        // R6: hold while disabled, then resume from the held count
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R6");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R6");

        // R5: run changes during the low phase must not count
        step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b1, "R5");
        step(1'b1, 1'b0, "R5");
        step(1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, "R5");

        // Random run patterns
        for (int i = 0; i < 500; i++) begin
            r = 1'($urandom);
            step(r, 1'($urandom), "R5");
        end

        // R1 + R4: clear in the middle of a run, then re-align
        clr = 1'b1;
        run = 1'b1;
        @(posedge clk); #2;
        check3("R1", {d8, d4, d2}, 3'b000);
        clr = 1'b0;
        m_cnt = 0;
        m_gate = 1'b0;
        step(1'b1, 1'b1, "R4");
        check3("R4", {d8, d4, d2}, 3'b111);
        for (int i = 0; i < 16; i++) step(1'b1, 1'b1, "R3");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule